// File: doc/BRIEF.md
# Serial GPIO expander shift engine

This block lets a chip drive and read up to 64 extra output pins and 64 extra input pins through four serial wires and a chain of external shift registers. Software writes the wanted output levels into eight byte-wide output registers. The engine then runs frames. A frame pulses a load strobe, which makes the external input registers take a parallel snapshot of their pins. It then clocks a bit stream out on a data line while it clocks the input snapshot back in. At the end of the frame the received bits go into eight byte-wide input registers, all in the same clock cycle.

The number of 8-bit output ports and the number of 8-bit input ports are set separately in one register. A frame lasts as many bit times as the larger of the two port groups needs. The bit time is a fixed division of the system clock, taken from a small table of divider codes. The serial clock and the load strobe each have a polarity bit. The engine can run one frame for each request or can sample the inputs continuously. Software reaches everything through a byte-wide register bus: a write strobe, an address and write data, with read data returned combinationally from the address.

Top module: `serexp_top`

## Requirements
- R1: After reset every register reads 0x00, and the serial clock, load strobe and data-out pins are all low.
- R2: The output bytes at addresses 0x00..0x07 read back the last value written. Pin n is bit n%8 of byte n/8.
- R3: The port-count byte at 0x2B reads back exactly what was written. The low nibble is the number of input ports and the high nibble the number of output ports. A nibble above 8 acts as 8.
- R4: Bits 3:0 of the configuration byte at 0x2A select the bit time in system clocks: code 0x5 gives 32, 0x7 gives 8, 0xC gives 4, 0xD gives 3, 0xE gives 2, and every other code gives 1024. The load strobe is active for exactly one bit time.
- R5: Configuration bit 4 set makes the serial clock idle high and pulse low. Bit 5 set makes the load strobe idle high and pulse low. With a bit clear, the pin idles low and pulses high.
- R6: The control byte at 0x28 reads back bits 7, 2 and 1 as written, and its other bits read 0. Bit 7 enables the engine. With bit 2 clear, each write that sets bit 7 requests exactly one frame.
- R7: A frame is one load bit time followed by L = 8 x max(outputs, inputs) shift bit times. Data out is valid on the active serial clock edge. Bit k of the stream (k = 0 first) carries output pin L-1-k. Pins at or above 8 x outputs are sent as 0.
- R8: The bit sampled at stream position k lands on input pin L-1-k. Input bytes for banks at or above the input count read 0. The input bytes at 0x08..0x0F change only on the cycle after a frame completes.
- R9: While bit 7 of the control byte is clear, no frame runs. A running frame is abandoned without updating the input bytes, and the pins sit at their idle levels.
- R10: With bit 2 of the control byte set and the engine enabled, frames run back to back. The next load strobe begins two cycles after the last bit time ends.
- R11: Writes to the input bytes at 0x08..0x0F are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr |
| sio_clk | output | 1 | Serial shift clock |
| sio_load | output | 1 | Parallel-load strobe for the external input registers |
| sio_dout | output | 1 | Serial data to the external output chain |
| sio_din | input | 1 | Serial data from the external input chain |

## Verification
The case that is hardest to reach from the ports is a frame cut off part way, in continuous mode, while the input pins are changing. Back-to-back frames give the bench no idle moment in which the enable can be cleared safely. The stimulus starts continuous sampling with the shortest bit time and lets several frames finish. It then changes the external input pattern and clears the enable at a point that does not line up with a frame boundary. After that it checks that the load strobe stays quiet, that the pins rest at their inverted idle levels, and that the input bytes still hold the last completed frame. Every other vector runs one frame under its own divider, polarity and port-count mix. A behavioural chain model captures the serial stream and checks it against the output bytes.

// File: rtl/serexp_pkg.sv
package serexp_pkg;

  localparam int SX_BANKS  = 8;
  localparam int SX_BANK_W = 8;
  localparam int SX_CNT_W  = 11;

  localparam logic [5:0] ADR_RD_BASE = 6'h08;
  localparam logic [5:0] ADR_CTRL    = 6'h28;
  localparam logic [5:0] ADR_CFG     = 6'h2A;
  localparam logic [5:0] ADR_PORTS   = 6'h2B;

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_SHIFT} phase_t;

  // bit time in system clocks for a divider code
  function automatic logic [SX_CNT_W-1:0] bit_time(input logic [3:0] code);
    case (code)
      4'h5:    bit_time = 11'd32;
      4'h7:    bit_time = 11'd8;
      4'hC:    bit_time = 11'd4;
      4'hD:    bit_time = 11'd3;
      4'hE:    bit_time = 11'd2;
      default: bit_time = 11'd1024;
    endcase
  endfunction

  function automatic logic [3:0] port_clamp(input logic [3:0] n, input int lim);
    port_clamp = (int'(n) > lim) ? 4'(lim) : n;
  endfunction

endpackage

// File: rtl/serexp_regs.sv
module serexp_regs
  import serexp_pkg::*;
#(
  parameter int BANKS  = SX_BANKS,
  parameter int BANK_W = SX_BANK_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [5:0]              addr,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  input  logic                    rx_valid,
  input  logic [BANKS*BANK_W-1:0] rx_word,
  output logic [BANKS*BANK_W-1:0] tx_word,
  output logic                    run_en,
  output logic                    periodic,
  output logic                    oneshot,
  output logic                    pol_clk,
  output logic                    pol_ld,
  output logic [3:0]              div_code,
  output logic [3:0]              n_out,
  output logic [3:0]              n_in
);

  localparam int NPIN = BANKS * BANK_W;

  logic [BANK_W-1:0] wd_q [BANKS];
  logic [BANK_W-1:0] rd_q [BANKS];
  logic [NPIN-1:0]   rd_flat;
  logic              en_q;
  logic [1:0]        mode_q;
  logic [5:0]        cfg_q;
  logic [7:0]        ports_q;

  logic wr_ctrl, wr_cfg, wr_ports;
  assign wr_ctrl  = wr_en && (addr == ADR_CTRL);
  assign wr_cfg   = wr_en && (addr == ADR_CFG);
  assign wr_ports = wr_en && (addr == ADR_PORTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= 2'b00;
      cfg_q   <= 6'd0;
      ports_q <= 8'd0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata[7];
        mode_q <= wdata[2:1];
      end
      if (wr_cfg)   cfg_q   <= wdata[5:0];
      if (wr_ports) ports_q <= wdata;
    end
  end

  assign n_out = port_clamp(ports_q[7:4], BANKS);
  assign n_in  = port_clamp(ports_q[3:0], BANKS);

  genvar g;
  generate
    for (g = 0; g < BANKS; g++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          wd_q[g] <= '0;
        else if (wr_en && (addr == 6'(g)))
          wd_q[g] <= wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          rd_q[g] <= '0;
        else if (rx_valid)
          rd_q[g] <= (4'(g) < n_in) ? rx_word[g*BANK_W +: BANK_W] : '0;
      end
      assign tx_word[g*BANK_W +: BANK_W] = (4'(g) < n_out) ? wd_q[g] : '0;
      assign rd_flat[g*BANK_W +: BANK_W] = rd_q[g];
    end
  endgenerate

  assign run_en   = en_q;
  assign periodic = mode_q[1];
  assign oneshot  = wr_ctrl && wdata[7] && !wdata[2];
  assign pol_clk  = cfg_q[4];
  assign pol_ld   = cfg_q[5];
  assign div_code = cfg_q[3:0];

  always_comb begin
    rdata = 8'd0;
    for (int b = 0; b < BANKS; b++) begin
      if (addr == 6'(b))               rdata = wd_q[b];
      if (addr == ADR_RD_BASE + 6'(b)) rdata = rd_q[b];
    end
    if (addr == ADR_CTRL)  rdata = {en_q, 4'd0, mode_q, 1'b0};
    if (addr == ADR_CFG)   rdata = {2'b00, cfg_q};
    if (addr == ADR_PORTS) rdata = ports_q;
  end

  assert_ports_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ports |=> (ports_q == $past(wdata)));

  assert_ctrl_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (run_en == $past(wdata[7])));

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(rd_flat));

endmodule

// File: rtl/serexp_frame.sv
module serexp_frame
  import serexp_pkg::*;
#(
  parameter int BANKS  = SX_BANKS,
  parameter int BANK_W = SX_BANK_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_en,
  input  logic                    periodic,
  input  logic                    oneshot,
  input  logic [3:0]              div_code,
  input  logic                    pol_clk,
  input  logic                    pol_ld,
  input  logic [3:0]              n_out,
  input  logic [3:0]              n_in,
  input  logic [BANKS*BANK_W-1:0] tx_word,
  input  logic                    sdin,
  output logic                    sclk,
  output logic                    sload,
  output logic                    sdout,
  output logic                    rx_valid,
  output logic [BANKS*BANK_W-1:0] rx_word
);

  localparam int NPIN  = BANKS * BANK_W;
  localparam int LEN_W = $clog2(NPIN + 1);

  phase_t              phase_q, phase_d;
  logic [SX_CNT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0]    bit_q, bit_d, len_q, len_d;
  logic [NPIN-1:0]     osr_q, osr_d, isr_q, isr_d;
  logic                pend_q, pend_d, done_q, done_d;

  logic [SX_CNT_W-1:0] div, half;
  logic [3:0]          nmax;
  logic [LEN_W-1:0]    len_calc;
  logic                start;

  assign div      = bit_time(div_code);
  assign half     = div >> 1;
  assign nmax     = (n_out > n_in) ? n_out : n_in;
  assign len_calc = LEN_W'(nmax) * LEN_W'(BANK_W);
  assign start    = run_en && (periodic || pend_q);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    len_d   = len_q;
    osr_d   = osr_q;
    isr_d   = isr_q;
    pend_d  = pend_q || oneshot;
    done_d  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_LOAD;
          cnt_d   = '0;
          len_d   = len_calc;
          osr_d   = tx_word << (LEN_W'(NPIN) - len_calc);
          isr_d   = '0;
          pend_d  = oneshot;
        end
      end
      PH_LOAD: begin
        if (cnt_q == div - 11'd1) begin
          cnt_d = '0;
          bit_d = '0;
          if (len_q == '0) begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end else begin
            phase_d = PH_SHIFT;
          end
        end else begin
          cnt_d = cnt_q + 11'd1;
        end
      end
      PH_SHIFT: begin
        if (cnt_q == half - 11'd1)
          isr_d = {isr_q[NPIN-2:0], sdin};
        if (cnt_q == div - 11'd1) begin
          cnt_d = '0;
          osr_d = osr_q << 1;
          bit_d = bit_q + LEN_W'(1);
          if (bit_q == len_q - LEN_W'(1)) begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 11'd1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    if (!run_en) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      len_q   <= '0;
      osr_q   <= '0;
      isr_q   <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      len_q   <= len_d;
      osr_q   <= osr_d;
      isr_q   <= isr_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
    end
  end

  assign sclk     = ((phase_q == PH_SHIFT) && (cnt_q >= half)) ^ pol_clk;
  assign sload    = (phase_q == PH_LOAD) ^ pol_ld;
  assign sdout    = (phase_q == PH_SHIFT) && osr_q[NPIN-1];
  assign rx_valid = done_q;
  assign rx_word  = isr_q;

  assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (phase_q == PH_IDLE));

  assert_bit_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SHIFT) |-> (bit_q < len_q));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && run_en && periodic) |=> (phase_q == PH_LOAD));

endmodule

// File: rtl/serexp_top.sv
module serexp_top
  import serexp_pkg::*;
#(
  parameter int BANKS  = SX_BANKS,
  parameter int BANK_W = SX_BANK_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [5:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       sio_clk,
  output logic       sio_load,
  output logic       sio_dout,
  input  logic       sio_din
);

  localparam int NPIN = BANKS * BANK_W;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic            rx_valid, run_en, periodic, oneshot, pol_clk, pol_ld;
  logic [NPIN-1:0] rx_word, tx_word;
  logic [3:0]      div_code, n_out, n_in;

  serexp_regs #(.BANKS(BANKS), .BANK_W(BANK_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_ni),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .rx_valid (rx_valid),
    .rx_word  (rx_word),
    .tx_word  (tx_word),
    .run_en   (run_en),
    .periodic (periodic),
    .oneshot  (oneshot),
    .pol_clk  (pol_clk),
    .pol_ld   (pol_ld),
    .div_code (div_code),
    .n_out    (n_out),
    .n_in     (n_in)
  );

  serexp_frame #(.BANKS(BANKS), .BANK_W(BANK_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_ni),
    .run_en   (run_en),
    .periodic (periodic),
    .oneshot  (oneshot),
    .div_code (div_code),
    .pol_clk  (pol_clk),
    .pol_ld   (pol_ld),
    .n_out    (n_out),
    .n_in     (n_in),
    .tx_word  (tx_word),
    .sdin     (sio_din),
    .sclk     (sio_clk),
    .sload    (sio_load),
    .sdout    (sio_dout),
    .rx_valid (rx_valid),
    .rx_word  (rx_word)
  );

endmodule

// File: tb/sim_serexp_top.sv
module sim_serexp_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {ports, cfg, output pattern, input pattern}
  localparam bit [143:0] VECS [NV] = '{
    {8'h22, 8'h0E, 64'h0123_4567_89AB_A55A, 64'hFEDC_BA98_7654_C33C},
    {8'h13, 8'h1D, 64'h1111_2222_3333_F00F, 64'h0F1E_2D3C_4B5A_6978},
    {8'h81, 8'h2C, 64'h8040_2010_0804_0201, 64'hAAAA_AAAA_AAAA_AA96},
    {8'h48, 8'h37, 64'hDEAD_BEEF_CAFE_1234, 64'h1357_9BDF_2468_ACE0},
    {8'h10, 8'h05, 64'h0000_0000_0000_00C3, 64'hFFFF_FFFF_FFFF_FFFF},
    {8'h9A, 8'h0C, 64'hF0E1_D2C3_B4A5_9687, 64'h7869_5A4B_3C2D_1E0F},
    {8'h11, 8'h03, 64'h0000_0000_0000_005A, 64'h0000_0000_0000_00A5},
    {8'h00, 8'h0E, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       b_wr = 1'b0;
  logic [5:0] b_addr = '0;
  logic [7:0] b_wdata = '0;
  logic [7:0] b_rdata;
  logic       sio_clk, sio_load, sio_dout, sio_din;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // external chain model state
  logic        m_pclk = 1'b0, m_pld = 1'b0;
  int          m_len = 0;
  logic [63:0] ipat = '0, ishr = '0, oshr = '0;
  logic        prev_clk = 1'b0, prev_ld = 1'b0, lg_clk, lg_ld;
  int          load_cycles = 0, load_rises = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serexp_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .sio_clk(sio_clk),
    .sio_load(sio_load), .sio_dout(sio_dout), .sio_din(sio_din)
  );

  assign sio_din = ishr[63];

  always @(negedge clk) begin
    lg_clk = sio_clk ^ m_pclk;
    lg_ld  = sio_load ^ m_pld;
    if (lg_ld) begin
      load_cycles = load_cycles + 1;
      if (!prev_ld) load_rises = load_rises + 1;
      ishr <= ipat << (64 - m_len);
      oshr <= '0;
    end else if (lg_clk && !prev_clk) begin
      oshr <= {oshr[62:0], sio_dout};
      ishr <= ishr << 1;
    end
    prev_clk <= lg_clk;
    prev_ld  <= lg_ld;
  end

  function automatic int exp_div(input logic [3:0] c);
    case (c)
      4'h5: return 32; 4'h7: return 8; 4'hC: return 4;
      4'hD: return 3;  4'hE: return 2; default: return 1024;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); b_wr = 1'b1; b_addr = a; b_wdata = d;
    @(negedge clk); b_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); b_addr = a; #1; d = b_rdata;
  endtask

  task automatic read_inputs(output logic [63:0] w);
    logic [7:0] d;
    for (int b = 0; b < 8; b++) begin
      bus_read(6'(8 + b), d);
      w[b*8 +: 8] = d;
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [143:0] vv;
  logic [7:0]   v_ports, v_cfg, rb;
  logic [63:0]  v_w, v_i, v_exp_in, v_omask, got;
  int           nout_c, nin_c, dv;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(4);

    // R1: reset state
    bus_read(6'h00, rb); chk(rb == 8'h00, "R1 output byte", 64'(rb), 64'h0);
    bus_read(6'h08, rb); chk(rb == 8'h00, "R1 input byte", 64'(rb), 64'h0);
    bus_read(6'h28, rb); chk(rb == 8'h00, "R1 control", 64'(rb), 64'h0);
    bus_read(6'h2A, rb); chk(rb == 8'h00, "R1 config", 64'(rb), 64'h0);
    chk({sio_clk, sio_load, sio_dout} == 3'b000, "R1 idle pins",
        64'({sio_clk, sio_load, sio_dout}), 64'h0);

    // R3: exact readback
    bus_write(6'h2B, 8'hA7); bus_read(6'h2B, rb);
    chk(rb == 8'hA7, "R3 port-count readback", 64'(rb), 64'hA7);

    // R6: control readback keeps bits 7,2,1 only
    bus_write(6'h28, 8'h7E); bus_read(6'h28, rb);
    chk(rb == 8'h06, "R6 control readback", 64'(rb), 64'h06);
    bus_write(6'h28, 8'h00);

    for (int v = 0; v < NV; v++) begin
      vv = VECS[v];
      v_ports = vv[143:136]; v_cfg = vv[135:128]; v_w = vv[127:64]; v_i = vv[63:0];
      nout_c = (v_ports[7:4] > 4'd8) ? 8 : int'(v_ports[7:4]);  // R3 clamp
      nin_c  = (v_ports[3:0] > 4'd8) ? 8 : int'(v_ports[3:0]);
      dv = exp_div(v_cfg[3:0]);
      bus_write(6'h2A, v_cfg);
      bus_write(6'h2B, v_ports);
      for (int b = 0; b < 8; b++) bus_write(6'(b), v_w[b*8 +: 8]);
      m_pclk = v_cfg[4]; m_pld = v_cfg[5];
      m_len = 8 * ((nout_c > nin_c) ? nout_c : nin_c);
      ipat = v_i;
      wait_cycles(3);
      load_cycles = 0; load_rises = 0;
      bus_write(6'h28, 8'h80);
      wait_cycles((m_len + 1) * dv + 12);
      v_omask = '0; v_exp_in = '0;
      for (int j = 0; j < 64; j++) begin
        if (j < 8 * nout_c) v_omask[j] = 1'b1;
        if (j < 8 * nin_c)  v_exp_in[j] = v_i[j];
      end
      chk(oshr == (v_w & v_omask), "R7 serial output stream", oshr, v_w & v_omask);
      read_inputs(got);
      chk(got == v_exp_in, "R8 captured input bytes", got, v_exp_in);
      chk(load_cycles == dv, "R4 load strobe width", 64'(load_cycles), 64'(dv));
      chk(load_rises == 1, "R6 one frame per request", 64'(load_rises), 64'h1);
      chk({sio_clk, sio_load} == {v_cfg[4], v_cfg[5]}, "R5 idle polarity",
          64'({sio_clk, sio_load}), 64'({v_cfg[4], v_cfg[5]}));
      bus_read(6'h03, rb);
      chk(rb == v_w[31:24], "R2 output byte readback", 64'(rb), 64'(v_w[31:24]));
    end

    // R10: continuous sampling, back to back
    bus_write(6'h2A, 8'h0E); bus_write(6'h2B, 8'h11);
    m_pclk = 1'b0; m_pld = 1'b0; m_len = 8; ipat = 64'h3C;
    wait_cycles(3);
    load_rises = 0;
    bus_write(6'h28, 8'h84);
    wait_cycles(100);
    chk(load_rises >= 4, "R10 back-to-back frames", 64'(load_rises), 64'h4);
    bus_read(6'h08, rb); chk(rb == 8'h3C, "R10 periodic capture", 64'(rb), 64'h3C);
    ipat = 64'hC5;
    wait_cycles(97);
    bus_read(6'h08, rb); chk(rb == 8'hC5, "R10 periodic follows input", 64'(rb), 64'hC5);

    // R9: disable mid-run
    bus_write(6'h28, 8'h00);
    bus_write(6'h2A, 8'h3E);
    m_pclk = 1'b1; m_pld = 1'b1;
    wait_cycles(5);
    load_rises = 0; ipat = 64'h99;
    wait_cycles(200);
    chk(load_rises == 0, "R9 no frames while disabled", 64'(load_rises), 64'h0);
    chk({sio_clk, sio_load, sio_dout} == 3'b110, "R9 idle pins while disabled",
        64'({sio_clk, sio_load, sio_dout}), 64'h6);
    bus_read(6'h08, rb); chk(rb == 8'hC5, "R9 inputs held", 64'(rb), 64'hC5);

    // R11: input bytes ignore writes
    bus_write(6'h08, 8'h5A);
    bus_read(6'h08, rb); chk(rb == 8'hC5, "R11 write ignored", 64'(rb), 64'hC5);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule